// File: doc/BRIEF.md
# Load Forwarding Checker and Replay Gate

This block sits a few stages behind the early load lookup. That lookup hands a load data from a store queue entry after comparing only part of the address. For each load that reaches this stage, the block reads the full byte address, the access size and the age of the load, together with every queue entry that holds an executed store. It then decides whether the speculative choice was right. If the load took forwarded data, it finds out whether the data came from the correct store and whether forwarding was allowed for that pair at all. If the load went to the cache, it finds out whether an older store still hides the bytes it read.

Each load receives a result one cycle after it is presented. A load that fails these checks is flagged for replay. If a pending older store covers its bytes, the load is parked until that store retires and reports its cache write. One cycle later a release bit for the parked load tells the scheduler to issue it again, and the load then reads from the cache. A load that took forwarded data but had no older overlapping store is replayed at once, with no wait.

Top module: `fwd_verify`

## Requirements
- R1: A result appears on `res_valid` exactly one clock after `chk_valid` is sampled high, and never without a check.
- R2: The blocking store is the youngest valid store that is older than the load and overlaps it. Ages compare as unsigned numbers, and a smaller age is older. A store whose age is equal to or above the load's age is ignored.
- R3: Overlap is computed on full byte ranges [addr, addr+bytes). The size code maps 0/1/2/3 to 1/2/4/8 bytes. A store whose range only touches the load's range edge to edge does not overlap it.
- R4: A load that forwarded from the blocking store passes with cause 0 and no replay when three conditions all hold: the start addresses are equal, the load's byte count is at most the store's, and the store stays inside one 64-byte line.
- R5: If a load forwarded from the blocking store but the rules fail, the cause reports the first failed rule in this order: start address differs (cause 3), load wider than store (cause 4), store offset in its 64-byte line plus its byte count exceeds 64 (cause 5).
- R6: A load that forwarded from a store other than the blocker gets cause 2. A load that read the cache while a blocker exists gets cause 6. Both set `res_wait`, and `res_stag` carries the blocker's store tag.
- R7: A load that forwarded while no older overlapping store exists gets cause 1 and is replayed without waiting. A load with no blocker that read the cache passes with cause 0.
- R8: A waiting load's bit in `rel_mask` pulses for exactly one cycle, one clock after `cwr_valid` carries the tag of its blocking store. A later write with the same tag releases it no more.
- R9: If the blocker's cache write is reported in the same cycle as the check, the load is released on the next clock and is not parked.
- R10: Reset clears `res_valid`, `res_wait` and `rel_mask`, and drops every parked load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | A load is presented for checking |
| chk_ltag | input | LTAGW | Load tag |
| chk_addr | input | AW | Full byte address of the load |
| chk_size | input | 2 | Load size code (0..3 = 1,2,4,8 bytes) |
| chk_age | input | AGEW | Load age, smaller is older |
| chk_fwd | input | 1 | Load took forwarded data |
| chk_fwd_idx | input | IDXW | Queue entry the data came from |
| st_valid | input | NUM_ST | Entry holds an executed, not yet written store |
| st_addr | input | NUM_ST*AW | Store start addresses, entry i at [i*AW +: AW] |
| st_size | input | NUM_ST*2 | Store size codes |
| st_age | input | NUM_ST*AGEW | Store ages |
| st_tag | input | NUM_ST*STAGW | Store tags |
| cwr_valid | input | 1 | A retired store wrote the cache |
| cwr_tag | input | STAGW | Tag of that store |
| res_valid | output | 1 | Result valid |
| res_replay | output | 1 | Load must be replayed |
| res_wait | output | 1 | Replay waits for a store's cache write |
| res_cause | output | 3 | Cause code (R4 to R7) |
| res_ltag | output | LTAGW | Tag of the checked load |
| res_stag | output | STAGW | Tag of the blocking store |
| rel_mask | output | 2**LTAGW | One release bit per load tag |

## Verification
A wrong choice of blocker shows up one cycle after the check, as a wrong cause code or a wrong `res_stag`. A parked entry that is lost or stale shows up only when a cache write arrives: the release bit is missing, appears for the wrong load, or appears a second time. The bench therefore parks loads on several stores and then retires those stores one by one. It checks every release mask one clock after each write, and checks the cycle after that as well.

// File: rtl/fwd_verify_pkg.sv
package fwd_verify_pkg;

  typedef enum logic [2:0] {
    CZ_OK        = 3'd0,
    CZ_NODEP     = 3'd1,
    CZ_WRONG_SRC = 3'd2,
    CZ_ADDR      = 3'd3,
    CZ_SIZE      = 3'd4,
    CZ_XLINE     = 3'd5,
    CZ_MISSED    = 3'd6
  } cause_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    size_bytes = 4'd1 << code;
  endfunction

endpackage

// File: rtl/fwd_dep_scan.sv
module fwd_dep_scan #(
  parameter int NUM_ST = 4,
  parameter int AW     = 32,
  parameter int AGEW   = 4,
  parameter int IDXW   = 2
) (
  input  logic [AW-1:0]          ld_addr,
  input  logic [1:0]             ld_size,
  input  logic [AGEW-1:0]        ld_age,
  input  logic [NUM_ST-1:0]      st_valid,
  input  logic [NUM_ST*AW-1:0]   st_addr,
  input  logic [NUM_ST*2-1:0]    st_size,
  input  logic [NUM_ST*AGEW-1:0] st_age,
  output logic                   hit,
  output logic [IDXW-1:0]        idx
);
  import fwd_verify_pkg::*;

  logic [AW:0]         l_lo, l_hi;
  logic [NUM_ST-1:0]   cand;
  logic [AGEW-1:0]     best_age;

  assign l_lo = {1'b0, ld_addr};
  assign l_hi = l_lo + {{(AW-3){1'b0}}, size_bytes(ld_size)};

  for (genvar g = 0; g < NUM_ST; g++) begin : g_st
    logic [AW:0] s_lo, s_hi;
    assign s_lo = {1'b0, st_addr[g*AW +: AW]};
    assign s_hi = s_lo + {{(AW-3){1'b0}}, size_bytes(st_size[g*2 +: 2])};
    assign cand[g] = st_valid[g] && (st_age[g*AGEW +: AGEW] < ld_age)
                     && (s_lo < l_hi) && (l_lo < s_hi);
  end

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    best_age = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      if (cand[i] && (!hit || st_age[i*AGEW +: AGEW] > best_age)) begin
        hit      = 1'b1;
        idx      = IDXW'(i);
        best_age = st_age[i*AGEW +: AGEW];
      end
    end
  end

endmodule

// File: rtl/fwd_rule_chk.sv
module fwd_rule_chk #(
  parameter int AW         = 32,
  parameter int IDXW       = 2,
  parameter int LINE_BYTES = 64
) (
  input  logic [AW-1:0]   ld_addr,
  input  logic [1:0]      ld_size,
  input  logic            fwd,
  input  logic [IDXW-1:0] fwd_idx,
  input  logic            hit,
  input  logic [IDXW-1:0] blk_idx,
  input  logic [AW-1:0]   blk_addr,
  input  logic [1:0]      blk_size,
  output fwd_verify_pkg::cause_e cause,
  output logic            need_wait
);
  import fwd_verify_pkg::*;

  localparam int LOFFW = $clog2(LINE_BYTES);

  logic [LOFFW+1:0] end_ofs;
  logic             crosses;

  assign end_ofs = {2'b00, blk_addr[LOFFW-1:0]}
                 + {{(LOFFW-2){1'b0}}, size_bytes(blk_size)};
  assign crosses = end_ofs > (LOFFW+2)'(LINE_BYTES);

  always_comb begin
    if (!hit)                              cause = fwd ? CZ_NODEP : CZ_OK;
    else if (!fwd)                         cause = CZ_MISSED;
    else if (fwd_idx != blk_idx)           cause = CZ_WRONG_SRC;
    else if (ld_addr != blk_addr)          cause = CZ_ADDR;
    else if (ld_size > blk_size)           cause = CZ_SIZE;
    else if (crosses)                      cause = CZ_XLINE;
    else                                   cause = CZ_OK;
  end

  assign need_wait = hit && (cause != CZ_OK);

endmodule

// File: rtl/fwd_hold_table.sv
module fwd_hold_table #(
  parameter int LTAGW = 4,
  parameter int STAGW = 4,
  localparam int NLD  = 2**LTAGW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [LTAGW-1:0] set_ltag,
  input  logic [STAGW-1:0] set_stag,
  input  logic             cwr_valid,
  input  logic [STAGW-1:0] cwr_tag,
  output logic [NLD-1:0]   rel_mask
);

  logic [NLD-1:0]   held_q, held_d, rel_d;
  logic [STAGW-1:0] blk_q [NLD];
  logic             park, blk_we;

  assign park   = set_en && !(cwr_valid && cwr_tag == set_stag);
  assign blk_we = park;

  always_comb begin
    held_d = held_q;
    rel_d  = '0;
    for (int j = 0; j < NLD; j++) begin
      if (held_q[j] && cwr_valid && blk_q[j] == cwr_tag) begin
        rel_d[j]  = 1'b1;
        held_d[j] = 1'b0;
      end
    end
    if (set_en) begin
      if (park) held_d[set_ltag] = 1'b1;
      else      rel_d[set_ltag]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      rel_mask <= '0;
    end else begin
      held_q   <= held_d;
      rel_mask <= rel_d;
    end
  end

  always_ff @(posedge clk) begin
    if (blk_we) blk_q[set_ltag] <= set_stag;
  end

endmodule

// File: rtl/fwd_verify.sv
module fwd_verify #(
  parameter int NUM_ST     = 4,
  parameter int AW         = 32,
  parameter int AGEW       = 4,
  parameter int LTAGW      = 4,
  parameter int STAGW      = 4,
  parameter int LINE_BYTES = 64,
  parameter int IDXW       = (NUM_ST > 1) ? $clog2(NUM_ST) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chk_valid,
  input  logic [LTAGW-1:0]          chk_ltag,
  input  logic [AW-1:0]             chk_addr,
  input  logic [1:0]                chk_size,
  input  logic [AGEW-1:0]           chk_age,
  input  logic                      chk_fwd,
  input  logic [IDXW-1:0]           chk_fwd_idx,
  input  logic [NUM_ST-1:0]         st_valid,
  input  logic [NUM_ST*AW-1:0]      st_addr,
  input  logic [NUM_ST*2-1:0]       st_size,
  input  logic [NUM_ST*AGEW-1:0]    st_age,
  input  logic [NUM_ST*STAGW-1:0]   st_tag,
  input  logic                      cwr_valid,
  input  logic [STAGW-1:0]          cwr_tag,
  output logic                      res_valid,
  output logic                      res_replay,
  output logic                      res_wait,
  output logic [2:0]                res_cause,
  output logic [LTAGW-1:0]          res_ltag,
  output logic [STAGW-1:0]          res_stag,
  output logic [2**LTAGW-1:0]       rel_mask
);
  import fwd_verify_pkg::*;

  logic             hit, need_wait;
  logic [IDXW-1:0]  blk_idx;
  logic [AW-1:0]    blk_addr;
  logic [1:0]       blk_size;
  logic [STAGW-1:0] blk_stag;
  cause_e           cause;

  logic             valid_q, wait_q;
  cause_e           cause_q;
  logic [LTAGW-1:0] ltag_q;
  logic [STAGW-1:0] stag_q;

  fwd_dep_scan #(.NUM_ST(NUM_ST), .AW(AW), .AGEW(AGEW), .IDXW(IDXW)) u_scan (
    .ld_addr (chk_addr),
    .ld_size (chk_size),
    .ld_age  (chk_age),
    .st_valid(st_valid),
    .st_addr (st_addr),
    .st_size (st_size),
    .st_age  (st_age),
    .hit     (hit),
    .idx     (blk_idx)
  );

  assign blk_addr = st_addr[blk_idx*AW +: AW];
  assign blk_size = st_size[blk_idx*2 +: 2];
  assign blk_stag = st_tag[blk_idx*STAGW +: STAGW];

  fwd_rule_chk #(.AW(AW), .IDXW(IDXW), .LINE_BYTES(LINE_BYTES)) u_rule (
    .ld_addr  (chk_addr),
    .ld_size  (chk_size),
    .fwd      (chk_fwd),
    .fwd_idx  (chk_fwd_idx),
    .hit      (hit),
    .blk_idx  (blk_idx),
    .blk_addr (blk_addr),
    .blk_size (blk_size),
    .cause    (cause),
    .need_wait(need_wait)
  );

  fwd_hold_table #(.LTAGW(LTAGW), .STAGW(STAGW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (chk_valid && need_wait),
    .set_ltag (chk_ltag),
    .set_stag (blk_stag),
    .cwr_valid(cwr_valid),
    .cwr_tag  (cwr_tag),
    .rel_mask (rel_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      valid_q <= chk_valid;
      wait_q  <= chk_valid && need_wait;
    end
  end

  always_ff @(posedge clk) begin
    if (chk_valid) begin
      cause_q <= cause;
      ltag_q  <= chk_ltag;
      stag_q  <= blk_stag;
    end
  end

  assign res_valid  = valid_q;
  assign res_wait   = wait_q;
  assign res_replay = valid_q && (cause_q != CZ_OK);
  assign res_cause  = cause_q;
  assign res_ltag   = ltag_q;
  assign res_stag   = stag_q;

endmodule

// File: rtl/fwd_verify_chk.sv
module fwd_verify_chk #(
  parameter int NLD = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           chk_valid,
  input logic           cwr_valid,
  input logic           res_valid,
  input logic           res_replay,
  input logic           res_wait,
  input logic [2:0]     res_cause,
  input logic [NLD-1:0] rel_mask
);

  assert_result_follows_check_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(chk_valid));

  assert_wait_needs_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_wait |-> (res_valid && res_replay));

  assert_nodep_no_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_cause == 3'd1) |-> !res_wait);

  assert_release_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_mask != '0) |-> $past(cwr_valid));

endmodule

bind fwd_verify fwd_verify_chk #(.NLD(2**LTAGW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chk_valid (chk_valid),
  .cwr_valid (cwr_valid),
  .res_valid (res_valid),
  .res_replay(res_replay),
  .res_wait  (res_wait),
  .res_cause (res_cause),
  .rel_mask  (rel_mask)
);

// File: tb/fwd_verify_bench.sv
module fwd_verify_bench;

  localparam int NROW = 13;
  // {ltag[4], addr[32], size[2], age[4], fwd[1], idx[2], cause[3], wait[1], stag[4]}
  localparam logic [52:0] VEC [NROW] = '{
    {4'd1,  32'h0000_1000, 2'd2, 4'd7, 1'b1, 2'd1, 3'd0, 1'b0, 4'd0},  // R4
    {4'd1,  32'h0000_1000, 2'd2, 4'd7, 1'b1, 2'd0, 3'd2, 1'b1, 4'd2},  // R6 wrong source
    {4'd2,  32'h0000_1000, 2'd3, 4'd7, 1'b1, 2'd1, 3'd4, 1'b1, 4'd2},  // R5 size
    {4'd3,  32'h0000_1002, 2'd1, 4'd7, 1'b1, 2'd1, 3'd3, 1'b1, 4'd2},  // R5 addr
    {4'd4,  32'h0000_1000, 2'd2, 4'd4, 1'b1, 2'd0, 3'd0, 1'b0, 4'd0},  // R2 younger store ignored
    {4'd5,  32'h0000_203C, 2'd2, 4'd9, 1'b1, 2'd2, 3'd5, 1'b1, 4'd3},  // R5 line cross
    {4'd6,  32'h0000_5000, 2'd2, 4'd9, 1'b0, 2'd0, 3'd0, 1'b0, 4'd0},  // R7 clean cache read
    {4'd7,  32'h0000_5000, 2'd2, 4'd9, 1'b1, 2'd3, 3'd1, 1'b0, 4'd0},  // R7 no dependence
    {4'd8,  32'h0000_3000, 2'd1, 4'd9, 1'b0, 2'd0, 3'd6, 1'b1, 4'd4},  // R6 missed
    {4'd9,  32'h0000_3000, 2'd0, 4'd3, 1'b0, 2'd0, 3'd0, 1'b0, 4'd0},  // R2 equal-age-or-younger
    {4'd10, 32'h0000_1008, 2'd0, 4'd7, 1'b0, 2'd0, 3'd0, 1'b0, 4'd0},  // R3 touching edge
    {4'd11, 32'h0000_0FFF, 2'd1, 4'd7, 1'b1, 2'd0, 3'd2, 1'b1, 4'd2},  // R3 partial overlap
    {4'd13, 32'h0000_1001, 2'd3, 4'd7, 1'b1, 2'd1, 3'd3, 1'b1, 4'd2}   // R5 priority addr over size
  };

  logic        clk, rst_n;
  logic        chk_valid, chk_fwd, cwr_valid;
  logic [3:0]  chk_ltag, chk_age, cwr_tag;
  logic [31:0] chk_addr;
  logic [1:0]  chk_size, chk_fwd_idx;
  logic [3:0]  st_valid;
  logic [127:0] st_addr;
  logic [7:0]  st_size;
  logic [15:0] st_age, st_tag;
  logic        res_valid, res_replay, res_wait;
  logic [2:0]  res_cause;
  logic [3:0]  res_ltag, res_stag;
  logic [15:0] rel_mask;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fwd_verify u_fwd_verify (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_ltag(chk_ltag),
    .chk_addr(chk_addr), .chk_size(chk_size), .chk_age(chk_age), .chk_fwd(chk_fwd),
    .chk_fwd_idx(chk_fwd_idx), .st_valid(st_valid), .st_addr(st_addr),
    .st_size(st_size), .st_age(st_age), .st_tag(st_tag), .cwr_valid(cwr_valid),
    .cwr_tag(cwr_tag), .res_valid(res_valid), .res_replay(res_replay),
    .res_wait(res_wait), .res_cause(res_cause), .res_ltag(res_ltag),
    .res_stag(res_stag), .rel_mask(rel_mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    chk_valid = 1'b0;
    cwr_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    chk_ltag = '0; chk_addr = '0; chk_size = '0; chk_age = '0;
    chk_fwd = 1'b0; chk_fwd_idx = '0; cwr_tag = '0;
    st_valid = 4'hF;
    st_addr  = {32'h0000_3000, 32'h0000_203C, 32'h0000_1000, 32'h0000_1000};
    st_size  = {2'd1, 2'd3, 2'd2, 2'd3};
    st_age   = {4'd4, 4'd3, 4'd5, 4'd2};
    st_tag   = {4'd4, 4'd3, 4'd2, 4'd1};
    repeat (3) step();
    check("R10 reset res_valid", 32'(res_valid), 0);
    check("R10 reset res_wait", 32'(res_wait), 0);
    check("R10 reset rel_mask", 32'(rel_mask), 0);
    rst_n = 1'b1;
    step();
    check("R1 no check no result", 32'(res_valid), 0);

    for (int r = 0; r < NROW; r++) begin
      chk_valid   = 1'b1;
      chk_ltag    = VEC[r][52:49];
      chk_addr    = VEC[r][48:17];
      chk_size    = VEC[r][16:15];
      chk_age     = VEC[r][14:11];
      chk_fwd     = VEC[r][10];
      chk_fwd_idx = VEC[r][9:8];
      step();
      check($sformatf("R1 row %0d valid", r), 32'(res_valid), 1);
      check($sformatf("R4-cause row %0d (R2 R3 R5 R6 R7)", r), 32'(res_cause), 32'(VEC[r][7:5]));
      check($sformatf("R6 row %0d replay", r), 32'(res_replay), 32'(VEC[r][7:5] != 3'd0));
      check($sformatf("R6 row %0d wait", r), 32'(res_wait), 32'(VEC[r][4]));
      check($sformatf("R1 row %0d ltag", r), 32'(res_ltag), 32'(VEC[r][52:49]));
      if (VEC[r][4]) check($sformatf("R6 row %0d stag", r), 32'(res_stag), 32'(VEC[r][3:0]));
      check($sformatf("R8 row %0d no release", r), 32'(rel_mask), 0);
    end

    idle();
    step();
    check("R1 result drops after check", 32'(res_valid), 0);
    cwr_valid = 1'b1; cwr_tag = 4'd2;
    step();
    check("R8 release on store 2", 32'(rel_mask), 32'h280E);
    idle();
    step();
    check("R8 single pulse", 32'(rel_mask), 0);
    cwr_valid = 1'b1; cwr_tag = 4'd2;
    step();
    check("R8 no second release", 32'(rel_mask), 0);
    cwr_tag = 4'd3;
    step();
    check("R8 release on store 3", 32'(rel_mask), 32'h0020);

    chk_valid = 1'b1; chk_ltag = 4'd12; chk_addr = 32'h0000_3000;
    chk_size = 2'd1; chk_age = 4'd9; chk_fwd = 1'b0; chk_fwd_idx = 2'd0;
    cwr_valid = 1'b1; cwr_tag = 4'd4;
    step();
    check("R9 same-cycle wait flagged", 32'(res_wait), 1);
    check("R9 same-cycle release", 32'(rel_mask), 32'h1100);
    chk_valid = 1'b0;
    step();
    check("R9 not parked", 32'(rel_mask), 0);

    cwr_valid = 1'b0;
    chk_valid = 1'b1; chk_ltag = 4'd14;
    step();
    check("R6 parked before reset", 32'(res_wait), 1);
    chk_valid = 1'b0;
    rst_n = 1'b0;
    step();
    check("R10 reset drops result", 32'(res_valid), 0);
    rst_n = 1'b1;
    cwr_valid = 1'b1; cwr_tag = 4'd4;
    step();
    check("R10 parked load dropped", 32'(rel_mask), 0);
    idle();
    step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule